// File: doc/BRIEF.md
# Vector String Range Compare Unit

This unit tests every element of a 128-bit source vector against a list of ranges. The ranges come from a 128-bit bounds vector, read as consecutive element pairs. A 128-bit control vector, laid out like the bounds vector, gives each bound its own acceptance conditions. An element counts as a hit when it satisfies both bounds of at least one pair. The per-element hit can be complemented.

The result takes one of two forms:
- **Mask mode:** each hit element is flooded with ones.
- **Index mode:** the result is the byte offset of the first event.

In both modes a 2-bit condition code summarises how the first hit relates to the first zero element. Zero search is optional.

After a one-cycle `start` pulse the unit latches its operands. It then walks the source one element per cycle and raises `done`. The outputs then hold until the next `start`.

Top module: `vec_range_cmp`

## Requirements
- R1: `elem_size` 0, 1 and 2 select elements of 1, 2 and 4 bytes. Element i sits at byte offset i*size, and byte offset 0 is bits 127:120 of every vector.
- R2: Each bound is tested against the most significant byte of the control element at the same index. In that byte, bit 7 accepts source equal to the bound, bit 6 accepts source below the bound, and bit 5 accepts source above the bound. All comparisons are unsigned at element width.
- R3: Bounds form pairs (0,1), (2,3) and so on. An element hits when both bounds of any pair accept it.
- R4: With `invert` high, each element's hit value is complemented before any result is formed.
- R5: In mask mode (`mask_mode`=1), every bit of a hit element is 1 and every bit of any other element is 0.
- R6: In index mode, bits 127:64 hold the smaller of two byte offsets: the first hit and the first zero element. Bits 63:0 are zero, and 16 means no event.
- R7: With `zero_search` low, no element is treated as zero. A zero-valued element then neither ends the scan nor affects the index or the condition code.
- R8: The condition code `cc` is set as follows:
  - 3 when there is no hit and no zero.
  - 1 when there is a hit and no zero.
  - 2 when the first hit lies strictly before the first zero.
  - 0 otherwise.
- R9: `done` rises no later than 16/size+1 cycles after `start`. In index mode the scan may stop early, at the first hit or at the first zero. `done`, `result` and `cc` then hold until the next `start`, which clears `done`.
- R10: After reset, `done` is 0, `result` is 0 and `cc` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Latch operands and begin a scan |
| elem_size | input | 2 | Element size code (0, 1, 2) |
| invert | input | 1 | Complement per-element hit |
| zero_search | input | 1 | Enable zero-element detection |
| mask_mode | input | 1 | 1 selects mask result, 0 selects index result |
| src_vec | input | 128 | Source elements |
| bnd_vec | input | 128 | Range bounds |
| ctl_vec | input | 128 | Per-bound condition bits |
| done | output | 1 | Scan complete, outputs valid |
| result | output | 128 | Mask or index result |
| cc | output | 2 | Condition code |

## Verification
The in-RTL assertions check several properties on every cycle:
- Outputs hold while `done` is high, and `busy` and `done` are never high together.
- The scan offset stays aligned to the element size.
- The condition code agrees with the result: for example, code 3 implies an empty mask or an index of 16, and code 2 implies an index below 16.

Only the bench's scenarios can show that the comparisons themselves are right. That covers the meaning of each condition bit, the pairing of bounds, inversion, and zero handling with the search enabled and disabled. Those scenarios compare against a reference model across all three element sizes and both result modes.

// File: rtl/vec_range_cmp.sv
module vec_range_cmp #(
  parameter int VW = 128,
  localparam int NB = VW / 8,
  localparam int IW = $clog2(NB) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    elem_size,
  input  logic          invert,
  input  logic          zero_search,
  input  logic          mask_mode,
  input  logic [VW-1:0] src_vec,
  input  logic [VW-1:0] bnd_vec,
  input  logic [VW-1:0] ctl_vec,
  output logic          done,
  output logic [VW-1:0] result,
  output logic [1:0]    cc
);

  logic [VW-1:0] src_q, bnd_q, ctl_q, mask_q;
  logic [1:0]    esz_q;
  logic          inv_q, mm_q, busy_q, done_q;
  logic [IW-1:0] off_q, fm_q, fz_q, fz_new, minv;
  logic [31:0]   cur;
  logic          any_pair, hit, last, stop_zero;
  int            sz_q, nel_q;

  function automatic logic [31:0] pick(input logic [VW-1:0] v, input int boff, input logic [1:0] es);
    logic [VW-1:0] s;
    s = v << (boff * 8);
    case (es)
      2'd0:    pick = {24'h0, s[VW-1 -: 8]};
      2'd1:    pick = {16'h0, s[VW-1 -: 16]};
      default: pick = s[VW-1 -: 32];
    endcase
  endfunction

  function automatic logic accept(input logic [31:0] d, input logic [31:0] b, input logic [7:0] c);
    if (d < b)      accept = c[6];
    else if (d > b) accept = c[5];
    else            accept = c[7];
  endfunction

  always_comb begin
    fz_new = IW'(NB);
    if (zero_search)
      for (int i = NB - 1; i >= 0; i--)
        if ((i % (1 << elem_size)) == 0 && pick(src_vec, i, elem_size) == 32'd0)
          fz_new = IW'(i);
  end

  assign sz_q  = 1 << esz_q;
  assign nel_q = NB >> esz_q;
  assign cur   = pick(src_q, int'(off_q), esz_q);

  always_comb begin
    any_pair = 1'b0;
    for (int p = 0; p < NB / 2; p++) begin
      if (2 * p + 1 < nel_q) begin
        if (accept(cur, pick(bnd_q, (2 * p) * sz_q, esz_q), ctl_q[VW-1 - ((2 * p) * sz_q) * 8 -: 8]) &&
            accept(cur, pick(bnd_q, (2 * p + 1) * sz_q, esz_q), ctl_q[VW-1 - ((2 * p + 1) * sz_q) * 8 -: 8]))
          any_pair = 1'b1;
      end
    end
  end

  assign hit       = any_pair ^ inv_q;
  assign last      = (int'(off_q) + sz_q) >= NB;
  assign stop_zero = !mm_q && (off_q == fz_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      bnd_q  <= '0;
      ctl_q  <= '0;
      mask_q <= '0;
      esz_q  <= 2'd0;
      inv_q  <= 1'b0;
      mm_q   <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      off_q  <= '0;
      fm_q   <= IW'(NB);
      fz_q   <= IW'(NB);
    end else if (start) begin
      src_q  <= src_vec;
      bnd_q  <= bnd_vec;
      ctl_q  <= ctl_vec;
      mask_q <= '0;
      esz_q  <= elem_size;
      inv_q  <= invert;
      mm_q   <= mask_mode;
      busy_q <= 1'b1;
      done_q <= 1'b0;
      off_q  <= '0;
      fm_q   <= IW'(NB);
      fz_q   <= fz_new;
    end else if (busy_q) begin
      if (stop_zero) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        if (hit) begin
          if (fm_q == IW'(NB)) fm_q <= off_q;
          mask_q <= mask_q | (({VW{1'b1}} << (VW - (8 << esz_q))) >> (int'(off_q) * 8));
        end
        if ((hit && !mm_q) || last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
        off_q <= off_q + IW'(sz_q);
      end
    end
  end

  assign minv   = (fm_q < fz_q) ? fm_q : fz_q;
  assign done   = done_q;
  assign result = mm_q ? mask_q : {{(VW/2 - IW){1'b0}}, minv, {(VW/2){1'b0}}};
  assign cc     = (fm_q == IW'(NB) && fz_q == IW'(NB)) ? 2'd3 :
                  (fz_q == IW'(NB))                    ? 2'd1 :
                  (fm_q < fz_q)                        ? 2'd2 : 2'd0;

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(busy_q && done_q)); // R9
  AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result) && $stable(cc))); // R9
  AST_OFF_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((int'(off_q) % sz_q) == 0 && int'(off_q) < NB)); // R1
  AST_MASK_EMPTY_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mm_q && cc == 2'd3) |-> (result == '0)); // R5
  AST_IDX_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mm_q && cc == 2'd3) |-> (result[VW-1:VW/2] == (VW/2)'(NB))); // R8
  AST_IDX_EARLY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !mm_q && cc == 2'd2) |-> (result[VW-1:VW/2] < (VW/2)'(NB))); // R6

endmodule

// File: tb/sim_vec_range_cmp.sv
`timescale 1ns/1ps
module sim_vec_range_cmp;
  logic clk = 0, rst_n = 0, start = 0;
  logic [1:0] elem_size = 0;
  logic invert = 0, zero_search = 0, mask_mode = 1;
  logic [127:0] src_vec = 0, bnd_vec = 0, ctl_vec = 0;
  logic done;
  logic [127:0] result;
  logic [1:0] cc;
  int tests = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  vec_range_cmp u0 (.clk(clk), .rst_n(rst_n), .start(start), .elem_size(elem_size),
    .invert(invert), .zero_search(zero_search), .mask_mode(mask_mode),
    .src_vec(src_vec), .bnd_vec(bnd_vec), .ctl_vec(ctl_vec),
    .done(done), .result(result), .cc(cc));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R9 actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [31:0] elt(input logic [127:0] v, input int i, input int sz);
    logic [127:0] t;
    t = v >> (128 - (i + 1) * sz * 8);
    return (sz == 4) ? t[31:0] : (t[31:0] & ((32'h1 << (sz * 8)) - 1));
  endfunction

  function automatic logic okb(input logic [31:0] d, input logic [31:0] l, input logic [7:0] c);
    return (d < l) ? c[6] : (d > l) ? c[5] : c[7];
  endfunction

  function automatic void model(output logic [127:0] r, output logic [1:0] c);
    int sz, n, fz, fm;
    logic [127:0] m;
    sz = 1 << elem_size; n = 16 / sz; fz = 16; fm = 16; m = 0;
    if (zero_search)
      for (int i = n - 1; i >= 0; i--) if (elt(src_vec, i, sz) == 0) fz = i * sz;
    for (int i = 0; i < n; i++) begin
      logic h;
      h = 0;
      for (int p = 0; p < n / 2; p++) begin
        logic [7:0] c0, c1;
        c0 = ctl_vec[127 - (2 * p) * sz * 8 -: 8];
        c1 = ctl_vec[127 - (2 * p + 1) * sz * 8 -: 8];
        if (okb(elt(src_vec, i, sz), elt(bnd_vec, 2 * p, sz), c0) &&
            okb(elt(src_vec, i, sz), elt(bnd_vec, 2 * p + 1, sz), c1)) h = 1;
      end
      h = h ^ invert;
      if (h) begin
        if (fm == 16) fm = i * sz;
        for (int b = 0; b < sz * 8; b++) m[127 - i * sz * 8 - b] = 1'b1;
      end
    end
    if (mask_mode) r = m;
    else r = {64'(fm < fz ? fm : fz), 64'd0};
    if (fm == 16 && fz == 16) c = 3;
    else if (fz == 16) c = 1;
    else if (fm < fz) c = 2;
    else c = 0;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(input string tag);
    logic [127:0] er;
    logic [1:0] ec;
    int cnt;
    model(er, ec);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    cnt = 0;
    while (!done && cnt < 40) begin @(negedge clk); cnt++; end
    chk("R9 latency", 128'(cnt <= (16 >> elem_size) + 1), 128'd1);
    chk(tag, result, er);
    chk("R8", 128'(cc), 128'(ec));
    if (mask_mode) chk("R5", result, er); else chk("R6", result, er);
  endtask

  task automatic setup(input logic [1:0] es, input logic iv, input logic zs, input logic mm,
                       input logic [127:0] s, input logic [127:0] b, input logic [127:0] c);
    elem_size = es; invert = iv; zero_search = zs; mask_mode = mm;
    src_vec = s; bnd_vec = b; ctl_vec = c;
  endtask

  function automatic logic [7:0] rbyte();
    return ($urandom_range(0, 1) == 1) ? 8'($urandom_range(0, 6)) : 8'($urandom);
  endfunction

  initial begin
    logic [127:0] held;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    chk("R10 done", 128'(done), 128'd0);
    chk("R10 result", result, 128'd0);
    chk("R10 cc", 128'(cc), 128'd3);
    rst_n = 1;

    setup(0, 0, 0, 1, 128'h1041_2041_5555_5555_5555_5555_5555_5555,
          128'h4141_0000_0000_0000_0000_0000_0000_0000,
          128'h8080_0000_0000_0000_0000_0000_0000_0000);
    run_case("R2 equal");
    setup(0, 0, 0, 1, 128'h2021_5F60_3000_0000_0000_0000_0000_0000,
          128'h2060_0000_0000_0000_0000_0000_0000_0000,
          128'h2040_0000_0000_0000_0000_0000_0000_0000);
    run_case("R2 strict range");
    setup(1, 0, 0, 0, 128'h0100_0300_0500_0700_0900_0B00_0D00_0F00,
          128'h0000_FFFF_0800_0A00_0000_0000_0000_0000,
          128'h0000_0000_A000_C000_0000_0000_0000_0000);
    run_case("R3 second pair");
    setup(1, 1, 0, 1, 128'h0100_0300_0500_0700_0900_0B00_0D00_0F00,
          128'h0000_FFFF_0800_0A00_0000_0000_0000_0000,
          128'h0000_0000_A000_C000_0000_0000_0000_0000);
    run_case("R4 invert");
    setup(0, 0, 1, 0, 128'h3300_4141_4141_4141_4141_4141_4141_4141,
          128'h4141_0000_0000_0000_0000_0000_0000_0000,
          128'h8080_0000_0000_0000_0000_0000_0000_0000);
    run_case("R7 zero on");
    chk("R7 zero index", result, {64'd1, 64'd0});
    zero_search = 0;
    run_case("R7 zero off");
    chk("R7 no zero", result, {64'd2, 64'd0});
    setup(2, 0, 1, 1, 128'h0000_0100_0000_0000_0001_0000_0000_0200,
          128'h0000_0100_0000_0200_0000_0000_0000_0000,
          128'hA000_0000_C000_0000_0000_0000_0000_0000);
    run_case("R1 word");
    held = result;
    repeat (3) @(negedge clk);
    chk("R9 hold result", result, held);
    chk("R9 hold done", 128'(done), 128'd1);

    for (int k = 0; k < 300; k++) begin
      logic [127:0] s, b, c;
      for (int j = 0; j < 16; j++) begin
        s[127 - 8*j -: 8] = rbyte();
        b[127 - 8*j -: 8] = rbyte();
        c[127 - 8*j -: 8] = 8'($urandom);
      end
      setup(2'($urandom_range(0, 2)), 1'($urandom), 1'($urandom), 1'($urandom), s, b, c);
      run_case("R3 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule